// File: doc/BRIEF.md
# Dual-Network Synchronization Monitor

This block watches two identical five-node Boolean networks that share one forcing bit, and it judges whether they have reached complete synchronization. On every clock it samples both node-state vectors and the forcing bit. It registers a per-node mismatch vector, in which a 1 marks a node whose two copies disagree. It raises a synchronized flag once the two networks have agreed on every node for a sustained run of samples.

A change of the forcing bit is known to produce short disagreement spikes even between networks that are already locked. The monitor therefore opens a short tolerance window at each forcing edge. A brief disagreement that lies wholly inside that window leaves the synchronized flag alone. Any other disagreement counts as a genuine loss of synchronization: it clears the flag and bumps a saturating event counter. A second counter records how many samples passed between reset and the first moment the flag rose, and then holds that value.

Top module: `dual_net_sync_monitor`

## Requirements
- R1: After each rising clock edge, `mismatch[i]` equals `net_a[i] ^ net_b[i]` as sampled at that edge (bit i is node i+1). A 0 means the node agrees.
- R2: `in_sync` rises at the edge that samples the AGREE_N-th (default 16) consecutive all-zero mismatch, and not earlier.
- R3: While `in_sync` is low, any nonzero mismatch sample restarts the count of consecutive all-zero samples.
- R4: A forcing edge is a sample where `force_in` differs from the previous sample (the previous value is taken as 0 after reset). The tolerance window covers the edge sample and the SPIKE_G (default 2) samples that follow it.
- R5: While `in_sync` is high, a run of nonzero mismatch samples no longer than SPIKE_G, with every sample inside a tolerance window, leaves `in_sync` high and `desync_count` unchanged.
- R6: While `in_sync` is high, a nonzero mismatch sample outside any window, or one that makes the run exceed SPIKE_G samples, drops `in_sync` at that edge and adds exactly 1 to `desync_count`, which saturates at 65535.
- R7: Mismatches seen while `in_sync` is low never change `desync_count`.
- R8: `transient_len` counts samples from reset up to and including the one that first raises `in_sync`, then holds that value through later losses and relocks. It saturates at its maximum.
- R9: Synchronous active-high `rst` clears `mismatch`, `in_sync`, `desync_count` and `transient_len` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| net_a | input | 5 | Node states of the first network |
| net_b | input | 5 | Node states of the second network |
| force_in | input | 1 | Common forcing bit driving both networks |
| mismatch | output | 5 | Registered per-node disagreement vector |
| in_sync | output | 1 | Complete synchronization flag |
| desync_count | output | 16 | Saturating count of losses of synchronization |
| transient_len | output | 16 | Samples from reset to the first lock |

## Verification
The window logic and the run-length limit can both decide the same sample. This happens when a disagreement begins on the last sample of a tolerance window and continues one sample past it. It also happens when a spike that starts on a forcing edge lasts one sample longer than SPIKE_G. The bench builds both cases and expects the flag to drop on exactly the first offending sample, not one earlier or later. It also checks that the relock count restarts in the same cycle as the loss. A behavioural model compares every output on every clock through these cases and through a long stretch of sparse random disagreement with random forcing.

// File: rtl/dnsm_pkg.sv
package dnsm_pkg;
    localparam int NODE_COUNT = 5;

    typedef struct packed {
        logic any_mis;
        logic loss;
    } mis_verdict_t;

    function automatic int unsigned width_of(input int unsigned maxval);
        int unsigned w;
        w = $clog2(maxval + 1);
        return (w < 1) ? 1 : w;
    endfunction
endpackage

// File: rtl/dnsm_edge_window.sv
module dnsm_edge_window
    import dnsm_pkg::*;
#(
    parameter int SPIKE_G = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         force_in,
    input  logic         any_mis,
    output mis_verdict_t verdict
);
    localparam int WW = width_of(SPIKE_G);
    localparam int RW = width_of(SPIKE_G + 1);
    localparam logic [WW-1:0] WIN_LOAD = WW'(SPIKE_G);
    localparam logic [RW-1:0] RUN_CAP  = RW'(SPIKE_G + 1);
    localparam logic [RW-1:0] RUN_OK   = RW'(SPIKE_G);

    logic          force_d;
    logic [WW-1:0] win_left;
    logic [RW-1:0] mis_run;
    logic [RW-1:0] run_now;
    logic          edge_seen;
    logic          win_open;

    always_comb begin
        edge_seen = force_in ^ force_d;
        win_open  = edge_seen | (win_left != '0);
        if (!any_mis)
            run_now = '0;
        else if (mis_run == RUN_CAP)
            run_now = mis_run;
        else
            run_now = mis_run + 1'b1;
        verdict.any_mis = any_mis;
        verdict.loss    = any_mis && !(win_open && (run_now <= RUN_OK));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            force_d  <= 1'b0;
            win_left <= '0;
            mis_run  <= '0;
        end else begin
            force_d <= force_in;
            mis_run <= run_now;
            if (edge_seen)
                win_left <= WIN_LOAD;
            else if (win_left != '0)
                win_left <= win_left - 1'b1;
        end
    end
endmodule

// File: rtl/dnsm_lock_tracker.sv
module dnsm_lock_tracker
    import dnsm_pkg::*;
#(
    parameter int AGREE_N = 16,
    parameter int DCNT_W  = 16,
    parameter int TLEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  mis_verdict_t      verdict,
    output logic              in_sync,
    output logic [DCNT_W-1:0] desync_count,
    output logic [TLEN_W-1:0] transient_len
);
    localparam int AW = width_of(AGREE_N);
    localparam logic [AW-1:0] AGREE_TOP = AW'(AGREE_N);

    logic [AW-1:0] agree_q;
    logic [AW-1:0] agree_nxt;
    logic          sync_nxt;
    logic          first_lock_seen;

    always_comb begin
        if (verdict.any_mis)
            agree_nxt = '0;
        else if (agree_q == AGREE_TOP)
            agree_nxt = agree_q;
        else
            agree_nxt = agree_q + 1'b1;

        if (verdict.loss)
            sync_nxt = 1'b0;
        else if (agree_nxt == AGREE_TOP)
            sync_nxt = 1'b1;
        else
            sync_nxt = in_sync;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            agree_q         <= '0;
            in_sync         <= 1'b0;
            desync_count    <= '0;
            transient_len   <= '0;
            first_lock_seen <= 1'b0;
        end else begin
            agree_q <= agree_nxt;
            in_sync <= sync_nxt;
            if (verdict.loss && in_sync && (desync_count != '1))
                desync_count <= desync_count + 1'b1;
            if (!first_lock_seen) begin
                if (transient_len != '1)
                    transient_len <= transient_len + 1'b1;
                first_lock_seen <= sync_nxt;
            end
        end
    end
endmodule

// File: rtl/dual_net_sync_monitor.sv
module dual_net_sync_monitor
    import dnsm_pkg::*;
#(
    parameter int AGREE_N = 16,
    parameter int SPIKE_G = 2,
    parameter int DCNT_W  = 16,
    parameter int TLEN_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NODE_COUNT-1:0] net_a,
    input  logic [NODE_COUNT-1:0] net_b,
    input  logic                  force_in,
    output logic [NODE_COUNT-1:0] mismatch,
    output logic                  in_sync,
    output logic [DCNT_W-1:0]     desync_count,
    output logic [TLEN_W-1:0]     transient_len
);
    logic [NODE_COUNT-1:0] diff_now;
    mis_verdict_t          verdict;

    assign diff_now = net_a ^ net_b;

    always_ff @(posedge clk) begin
        if (rst)
            mismatch <= '0;
        else
            mismatch <= diff_now;
    end

    dnsm_edge_window #(
        .SPIKE_G (SPIKE_G)
    ) u_window (
        .clk      (clk),
        .rst      (rst),
        .force_in (force_in),
        .any_mis  (|diff_now),
        .verdict  (verdict)
    );

    dnsm_lock_tracker #(
        .AGREE_N (AGREE_N),
        .DCNT_W  (DCNT_W),
        .TLEN_W  (TLEN_W)
    ) u_lock (
        .clk           (clk),
        .rst           (rst),
        .verdict       (verdict),
        .in_sync       (in_sync),
        .desync_count  (desync_count),
        .transient_len (transient_len)
    );
endmodule

// File: rtl/dual_net_sync_monitor_chk.sv
module dual_net_sync_monitor_chk
    import dnsm_pkg::*;
#(
    parameter int DCNT_W = 16,
    parameter int TLEN_W = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NODE_COUNT-1:0] net_a,
    input logic [NODE_COUNT-1:0] net_b,
    input logic [NODE_COUNT-1:0] mismatch,
    input logic                  in_sync,
    input logic [DCNT_W-1:0]     desync_count,
    input logic [TLEN_W-1:0]     transient_len
);
    // R1: registered per-node XOR
    a_r1_mismatch_xor: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (mismatch == $past(net_a ^ net_b)));

    // R2: lock only on an all-agree sample
    a_r2_lock_on_agree: assert property (@(posedge clk) disable iff (rst)
        $rose(in_sync) |-> (mismatch == '0));

    // R6: counter moves only with a loss of lock
    a_r6_count_with_loss: assert property (@(posedge clk) disable iff (rst)
        (desync_count != $past(desync_count)) |-> $fell(in_sync));

    // R6: counter never goes down
    a_r6_count_monotonic: assert property (@(posedge clk) disable iff (rst)
        desync_count >= $past(desync_count));

    // R8: transient length frozen once locked
    a_r8_transient_hold: assert property (@(posedge clk) disable iff (rst)
        in_sync |=> $stable(transient_len));
endmodule

bind dual_net_sync_monitor dual_net_sync_monitor_chk #(
    .DCNT_W (DCNT_W),
    .TLEN_W (TLEN_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .net_a         (net_a),
    .net_b         (net_b),
    .mismatch      (mismatch),
    .in_sync       (in_sync),
    .desync_count  (desync_count),
    .transient_len (transient_len)
);

// File: tb/dual_net_sync_monitor_bench.sv
`timescale 1ns/1ps
module dual_net_sync_monitor_bench;
    localparam int N = 16;
    localparam int G = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] net_a = '0;
    logic [4:0] net_b = '0;
    logic       force_in = 1'b0;
    logic [4:0] mismatch;
    logic       in_sync;
    logic [15:0] desync_count;
    logic [15:0] transient_len;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_cyc, m_last_edge, m_run, m_agree, m_dcnt, m_trans;
    int m_fprev, m_sync, m_seen;
    logic [4:0] m_mis;
    logic cur_f = 1'b0;

    dual_net_sync_monitor u_dual_net_sync_monitor (
        .clk           (clk),
        .rst           (rst),
        .net_a         (net_a),
        .net_b         (net_b),
        .force_in      (force_in),
        .mismatch      (mismatch),
        .in_sync       (in_sync),
        .desync_count  (desync_count),
        .transient_len (transient_len)
    );

    initial forever #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cyc = 0; m_last_edge = -1000; m_run = 0; m_agree = 0;
        m_dcnt = 0; m_trans = 0; m_fprev = 0; m_sync = 0; m_seen = 0;
        m_mis = '0;
    endtask

    task automatic model_sample(input logic [4:0] a, input logic [4:0] b, input logic f);
        logic [4:0] d;
        bit tol;
        m_cyc++;
        if (int'(f) != m_fprev) m_last_edge = m_cyc;
        m_fprev = int'(f);
        d = a ^ b;
        m_mis = d;
        if (d != 0) begin
            m_run++;
            m_agree = 0;
            tol = ((m_cyc - m_last_edge) <= G) && (m_run <= G);
            if (!tol && m_sync == 1) begin
                m_sync = 0;
                if (m_dcnt < 65535) m_dcnt++;
            end
        end else begin
            m_run = 0;
            m_agree++;
            if (m_agree >= N) m_sync = 1;
        end
        if (m_seen == 0) begin
            if (m_trans < 65535) m_trans++;
            if (m_sync == 1) m_seen = 1;
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic [4:0] a, input logic [4:0] b, input logic f);
        net_a = a; net_b = b; force_in = f;
        @(posedge clk);
        model_sample(a, b, f);
        @(negedge clk);
        chk("R1 mismatch", int'(mismatch), int'(m_mis));
        chk("R2 in_sync", int'(in_sync), m_sync);
        chk("R6 desync_count", int'(desync_count), m_dcnt);
        chk("R8 transient_len", int'(transient_len), m_trans);
    endtask

    task automatic agree_n(input int n, input logic f);
        for (int i = 0; i < n; i++) begin
            logic [4:0] v;
            v = 5'($urandom);
            if (f) v[4:3] = 2'b11;
            step(v, v, f);
        end
    endtask

    task automatic mis_n(input int n, input logic [4:0] mask, input logic f);
        for (int i = 0; i < n; i++) begin
            logic [4:0] v;
            v = 5'($urandom);
            if (f) v[4:3] = 2'b11;
            step(v, v ^ mask, f);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk("R9 mismatch", int'(mismatch), 0);
        chk("R9 in_sync", int'(in_sync), 0);
        chk("R9 desync_count", int'(desync_count), 0);
        chk("R9 transient_len", int'(transient_len), 0);

        // R7: disagreement before lock does not count
        mis_n(5, 5'b00001, 1'b0);
        chk("R7 no count before lock", int'(desync_count), 0);
        agree_n(N - 1, 1'b0);
        chk("R2 not yet at N-1", int'(in_sync), 0);
        mis_n(1, 5'b10000, 1'b0);
        agree_n(N - 1, 1'b0);
        chk("R3 run restarted", int'(in_sync), 0);
        agree_n(1, 1'b0);
        chk("R2 lock at N", int'(in_sync), 1);
        chk("R8 first lock length", int'(transient_len), 5 + (N - 1) + 1 + N);

        // R5: spike of G samples starting on a rising forcing edge
        cur_f = 1'b1;
        mis_n(G, 5'b00001, cur_f);
        chk("R5 spike tolerated", int'(in_sync), 1);
        agree_n(4, cur_f);
        chk("R5 count unchanged", int'(desync_count), 0);

        // R4: one-sample spike on the last window sample
        cur_f = 1'b0;
        agree_n(G, cur_f);
        mis_n(1, 5'b00100, cur_f);
        chk("R4 last window sample tolerated", int'(in_sync), 1);
        agree_n(5, cur_f);

        // R4/R6: spike crossing the window end
        cur_f = 1'b1;
        agree_n(G, cur_f);
        mis_n(1, 5'b00010, cur_f);
        chk("R4 inside window", int'(in_sync), 1);
        mis_n(1, 5'b00010, cur_f);
        chk("R6 outside window loss", int'(in_sync), 0);
        chk("R6 count one", int'(desync_count), 1);

        // R6: spike longer than G starting on an edge
        agree_n(N, cur_f);
        chk("R2 relock", int'(in_sync), 1);
        cur_f = 1'b0;
        mis_n(G, 5'b01000, cur_f);
        chk("R5 still locked at G", int'(in_sync), 1);
        mis_n(1, 5'b01000, cur_f);
        chk("R6 overlong spike loss", int'(in_sync), 0);
        chk("R6 count two", int'(desync_count), 2);

        // R6: disagreement with no forcing edge
        agree_n(N + 3, cur_f);
        mis_n(1, 5'b00001, cur_f);
        chk("R6 no-edge loss", int'(desync_count), 3);
        chk("R8 held after losses", int'(transient_len), 5 + (N - 1) + 1 + N);

        // mixed random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [4:0] v, msk;
            if (($urandom % 23) == 0) cur_f = ~cur_f;
            v = 5'($urandom);
            msk = (($urandom % 9) == 0) ? 5'($urandom) : 5'b0;
            if (cur_f) begin
                v[4:3] = 2'b11;
                msk[4:3] = 2'b00;
            end
            step(v, v ^ msk, cur_f);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule